// File: doc/BRIEF.md
# Capability enable register cascade

This block stores the enable bits that turn on capability registers and capability execution mode at the machine and supervisor privilege levels. It also stores a single top-level security bit that gates the whole feature. Software writes the three control registers through a small CSR-style port, one register per select value. Reads of those registers return *effective* values and not raw stored bits. A priority cascade masks every lower control as soon as a more privileged control is off.

The same masking logic drives four effective enable outputs. Privilege and decode logic elsewhere in the core use these outputs. The stored bits are never cleared by the cascade. When a higher-level restriction is lifted, the lower-level settings that software wrote come back unchanged. On a 64-bit configuration, two narrowing inputs signal that a lower level runs with a smaller register width than machine level. Each of them suppresses one register-enable bit, and that suppression feeds the cascade.

Top module: `cap_en_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all stored bits are zero, every select reads zero and all four effective outputs are low.
- R2: Register map. Select 0 is the security register, with its mode-enable in bit 0. Select 1 is machine level and select 2 is supervisor level; in each, bit 0 is register-enable and bit 1 is mode-enable. All other read bits are zero, and write data above bit 1 is dropped. Select 3 reads zero, and a write to it changes no state. A write is visible on the read port after the next rising clock edge.
- R3: A machine or supervisor write with register-enable 0 and mode-enable 1 is stored as both bits 0. The other three combinations are stored as written.
- R4: While the security bit is 0, the machine and supervisor fields read zero and all four effective outputs are low.
- R5: While the effective machine register-enable is 0, machine mode-enable and both supervisor bits read zero.
- R6: While the effective machine mode-enable is 0, both supervisor bits read zero.
- R7: While the effective supervisor register-enable is 0, supervisor mode-enable reads zero.
- R8: The cascade only masks values. Stored bits change only on a write, so clearing a restriction restores the earlier lower-level settings.
- R9: In a 64-bit configuration, a high `narrow_sup_i` (supervisor width below machine width) forces effective machine register-enable to zero, and R5 then applies.
- R10: In a 64-bit configuration, a high `narrow_user_i` (user width below machine width) forces effective supervisor register-enable to zero, and R7 then applies. Machine bits are unaffected.
- R11: The effective outputs always equal the fields that select 1 and select 2 return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csr_sel_i | input | 2 | Register select (0 security, 1 machine, 2 supervisor, 3 unused) |
| csr_we_i | input | 1 | Write enable for the selected register |
| csr_wdata_i | input | DATA_W | Write data |
| csr_rdata_o | output | DATA_W | Combinational read data of the selected register after masking |
| narrow_sup_i | input | 1 | Supervisor width is below machine width |
| narrow_user_i | input | 1 | User width is below machine width |
| m_reg_en_o | output | 1 | Effective machine register-enable |
| m_mode_en_o | output | 1 | Effective machine mode-enable |
| s_reg_en_o | output | 1 | Effective supervisor register-enable |
| s_mode_en_o | output | 1 | Effective supervisor mode-enable |

## Verification
Read data and effective outputs are combinational functions of the select, the stored bits and the narrowing inputs. A change of select or of a narrowing input therefore shows up within the same cycle, while a write shows up only after one rising edge. The driver changes inputs only on falling edges and holds a read's select through the following rising edge. The monitor samples 2 ns after that rising edge, so every write has already landed in state and no input is moving. Each queued item carries the expected read word and the expected four effective outputs. These values come from the bench's own model of the stored bits and the cascade.

// File: rtl/cap_en_pkg.sv
package cap_en_pkg;

  localparam int unsigned SEL_W    = 2;
  localparam int unsigned SEC_BIT  = 0;
  localparam int unsigned REG_BIT  = 0;
  localparam int unsigned MODE_BIT = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MACH = 2'd1,
    SEL_SUP  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic mode_en;
    logic reg_en;
  } en_pair_t;

  // Two-bit legal-value mapping: mode without register enable collapses to 00.
  function automatic en_pair_t legalize_pair(en_pair_t raw);
    en_pair_t res;
    res.reg_en  = raw.reg_en;
    res.mode_en = raw.mode_en & raw.reg_en;
    return res;
  endfunction

  // One cascade stage: a stored pair, gated by its parent and a width restriction.
  function automatic en_pair_t gate_pair(en_pair_t stored, logic parent_ok, logic narrow);
    en_pair_t res;
    res.reg_en  = parent_ok & stored.reg_en & ~narrow;
    res.mode_en = res.reg_en & stored.mode_en;
    return res;
  endfunction

endpackage

// File: rtl/cap_en_pair_reg.sv
module cap_en_pair_reg
  import cap_en_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     we_i,
  input  en_pair_t wr_i,
  output en_pair_t q_o
);

  en_pair_t q_r;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_r <= '0;
    end else if (we_i) begin
      q_r <= legalize_pair(wr_i);
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/cap_en_cascade.sv
module cap_en_cascade
  import cap_en_pkg::*;
#(
  parameter bit IS_64 = 1'b1
) (
  input  en_pair_t sec_q_i,
  input  en_pair_t mach_q_i,
  input  en_pair_t sup_q_i,
  input  logic     narrow_sup_i,
  input  logic     narrow_user_i,
  output logic     sec_on_o,
  output en_pair_t eff_mach_o,
  output en_pair_t eff_sup_o
);

  logic sup_narrow;
  logic user_narrow;

  generate
    if (IS_64) begin : g_wide
      assign sup_narrow  = narrow_sup_i;
      assign user_narrow = narrow_user_i;
    end else begin : g_narrow
      assign sup_narrow  = 1'b0;
      assign user_narrow = 1'b0 & narrow_user_i & narrow_sup_i;
    end
  endgenerate

  assign sec_on_o   = sec_q_i.mode_en & sec_q_i.reg_en;
  assign eff_mach_o = gate_pair(mach_q_i, sec_on_o, sup_narrow);
  assign eff_sup_o  = gate_pair(sup_q_i, eff_mach_o.mode_en, user_narrow);

endmodule

// File: rtl/cap_en_rdmux.sv
module cap_en_rdmux
  import cap_en_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              sec_on_i,
  input  en_pair_t          eff_mach_i,
  input  en_pair_t          eff_sup_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    case (csr_sel_e'(sel_i))
      SEL_SEC: begin
        rdata_o[SEC_BIT] = sec_on_i;
      end
      SEL_MACH: begin
        rdata_o[REG_BIT]  = eff_mach_i.reg_en;
        rdata_o[MODE_BIT] = eff_mach_i.mode_en;
      end
      SEL_SUP: begin
        rdata_o[REG_BIT]  = eff_sup_i.reg_en;
        rdata_o[MODE_BIT] = eff_sup_i.mode_en;
      end
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/cap_en_ctrl.sv
module cap_en_ctrl
  import cap_en_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter bit IS_64  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        csr_sel_i,
  input  logic              csr_we_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  input  logic              narrow_sup_i,
  input  logic              narrow_user_i,
  output logic              m_reg_en_o,
  output logic              m_mode_en_o,
  output logic              s_reg_en_o,
  output logic              s_mode_en_o
);

  localparam int LEVELS = 3;

  en_pair_t             wr_pair [LEVELS];
  en_pair_t             q_pair  [LEVELS];
  logic [LEVELS-1:0]    lvl_we;

  // Named internal events for the checker.
  en_pair_t sec_q;
  en_pair_t mach_q;
  en_pair_t sup_q;
  en_pair_t eff_mach;
  en_pair_t eff_sup;
  logic     sec_on;
  logic     wr_upper_set;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign lvl_we[g] = csr_we_i && (csr_sel_i == SEL_W'(g));
      if (g == 0) begin : g_sec
        assign wr_pair[g] = {csr_wdata_i[SEC_BIT], csr_wdata_i[SEC_BIT]};
      end else begin : g_env
        assign wr_pair[g] = {csr_wdata_i[MODE_BIT], csr_wdata_i[REG_BIT]};
      end
      cap_en_pair_reg u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (lvl_we[g]),
        .wr_i  (wr_pair[g]),
        .q_o   (q_pair[g])
      );
    end
  endgenerate

  assign sec_q        = q_pair[0];
  assign mach_q       = q_pair[1];
  assign sup_q        = q_pair[2];
  assign wr_upper_set = |csr_wdata_i[DATA_W-1:2];

  cap_en_cascade #(.IS_64(IS_64)) u_cascade (
    .sec_q_i       (sec_q),
    .mach_q_i      (mach_q),
    .sup_q_i       (sup_q),
    .narrow_sup_i  (narrow_sup_i),
    .narrow_user_i (narrow_user_i),
    .sec_on_o      (sec_on),
    .eff_mach_o    (eff_mach),
    .eff_sup_o     (eff_sup)
  );

  cap_en_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .sel_i      (csr_sel_i),
    .sec_on_i   (sec_on),
    .eff_mach_i (eff_mach),
    .eff_sup_i  (eff_sup),
    .rdata_o    (csr_rdata_o)
  );

  assign m_reg_en_o  = eff_mach.reg_en;
  assign m_mode_en_o = eff_mach.mode_en;
  assign s_reg_en_o  = eff_sup.reg_en;
  assign s_mode_en_o = eff_sup.mode_en;

endmodule

// File: rtl/cap_en_ctrl_chk.sv
module cap_en_ctrl_chk
  import cap_en_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter bit IS_64  = 1'b1
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [1:0]        csr_sel_i,
  input logic              csr_we_i,
  input logic [DATA_W-1:0] csr_rdata_o,
  input logic              narrow_sup_i,
  input logic              narrow_user_i,
  input logic              m_reg_en_o,
  input logic              m_mode_en_o,
  input logic              s_reg_en_o,
  input logic              s_mode_en_o,
  input logic              sec_on,
  input en_pair_t          mach_q,
  input en_pair_t          sup_q,
  input logic              wr_upper_set
);

  // R2
  upper_bits_dropped_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (csr_we_i && wr_upper_set) |=> (csr_rdata_o[DATA_W-1:2] == '0));

  // R3
  stored_pair_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(mach_q.mode_en && !mach_q.reg_en) && !(sup_q.mode_en && !sup_q.reg_en));

  // R4
  security_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !sec_on |-> (!m_reg_en_o && !m_mode_en_o && !s_reg_en_o && !s_mode_en_o));

  // R5
  mach_reg_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !m_reg_en_o |-> (!m_mode_en_o && !s_reg_en_o && !s_mode_en_o));

  // R6
  mach_mode_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !m_mode_en_o |-> (!s_reg_en_o && !s_mode_en_o));

  // R7
  sup_reg_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !s_reg_en_o |-> !s_mode_en_o);

  // R8
  state_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !csr_we_i |=> ($stable(mach_q) && $stable(sup_q)));

  // R9
  narrow_sup_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (IS_64 && narrow_sup_i) |-> !m_reg_en_o);

  // R10
  narrow_user_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (IS_64 && narrow_user_i) |-> !s_reg_en_o);

  // R11
  mach_read_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (csr_sel_i == SEL_MACH) |-> (csr_rdata_o[1:0] == {m_mode_en_o, m_reg_en_o}));

  // R11
  sup_read_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (csr_sel_i == SEL_SUP) |-> (csr_rdata_o[1:0] == {s_mode_en_o, s_reg_en_o}));

endmodule

bind cap_en_ctrl cap_en_ctrl_chk #(.DATA_W(DATA_W), .IS_64(IS_64)) u_chk (.*);

// File: tb/tb_cap_en_ctrl.sv
`timescale 1ns/1ps
module tb_cap_en_ctrl;

  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        sel;
  logic              we;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              nsup;
  logic              nuser;
  logic              m_re, m_me, s_re, s_me;

  always #4 clk = ~clk;

  cap_en_ctrl #(.DATA_W(DATA_W), .IS_64(1'b1)) dut (
    .clk_i(clk), .rst_i(rst), .csr_sel_i(sel), .csr_we_i(we), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .narrow_sup_i(nsup), .narrow_user_i(nuser),
    .m_reg_en_o(m_re), .m_mode_en_o(m_me), .s_reg_en_o(s_re), .s_mode_en_o(s_me)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Bench-side model of stored state.
  bit b_sec, b_mre, b_mme, b_sre, b_sme, b_nsup, b_nuser;

  logic [DATA_W-1:0] exp_rd_q [$];
  logic [3:0]        exp_eff_q [$];
  string             tag_q [$];

  function automatic logic [3:0] model_eff();
    bit mr, mm, sr, sm;
    mr = 0; mm = 0; sr = 0; sm = 0;
    if (b_sec) begin
      if (b_mre && !b_nsup) begin
        mr = 1;
        if (b_mme) begin
          mm = 1;
          if (b_sre && !b_nuser) begin
            sr = 1;
            sm = b_sme;
          end
        end
      end
    end
    return {sm, sr, mm, mr};
  endfunction

  function automatic logic [DATA_W-1:0] model_rd(logic [1:0] a);
    logic [3:0] e;
    e = model_eff();
    case (a)
      2'd0:    return {{(DATA_W-1){1'b0}}, b_sec};
      2'd1:    return {{(DATA_W-2){1'b0}}, e[1], e[0]};
      2'd2:    return {{(DATA_W-2){1'b0}}, e[3], e[2]};
      default: return '0;
    endcase
  endfunction

  task automatic do_write(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    sel = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
    case (a)
      2'd0: b_sec = d[0];
      2'd1: begin b_mre = d[0]; b_mme = d[0] ? d[1] : 1'b0; end
      2'd2: begin b_sre = d[0]; b_sme = d[0] ? d[1] : 1'b0; end
      default: ;
    endcase
  endtask

  task automatic set_narrow(bit s, bit u);
    @(negedge clk);
    nsup = s; nuser = u;
    b_nsup = s; b_nuser = u;
  endtask

  task automatic read_chk(logic [1:0] a, string tag);
    @(negedge clk);
    sel = a;
    exp_rd_q.push_back(model_rd(a));
    exp_eff_q.push_back(model_eff());
    tag_q.push_back(tag);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 4; i++) read_chk(2'(i), tag);
  endtask

  // Monitor: samples after the rising edge that follows each queued read.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_rd_q.size() > 0) begin
        logic [DATA_W-1:0] er;
        logic [3:0]        ee;
        string             t;
        er = exp_rd_q.pop_front();
        ee = exp_eff_q.pop_front();
        t  = tag_q.pop_front();
        tests++;
        if (rdata !== er) begin
          fails++;
          $display("FAIL %s sel=%0d rdata actual=%h expected=%h", t, sel, rdata, er);
        end
        tests++;
        if ({s_me, s_re, m_me, m_re} !== ee) begin
          fails++;
          $display("FAIL %s R11 effective actual=%b expected=%b", t,
                   {s_me, s_re, m_me, m_re}, ee);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel = '0; we = 1'b0; wdata = '0; nsup = 1'b0; nuser = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    read_all("R1 reset");

    // R2: plain writes, visible after the edge.
    do_write(2'd0, 64'h1);
    do_write(2'd1, 64'h3);
    do_write(2'd2, 64'h3);
    read_all("R2 map");

    // R2: upper write bits dropped.
    do_write(2'd1, {DATA_W{1'b1}});
    read_chk(2'd1, "R2 upper bits");
    // R2: select 3 write ignored.
    do_write(2'd3, {DATA_W{1'b1}});
    read_all("R2 unused select");

    // R3: illegal pair collapses; other combos kept.
    do_write(2'd2, 64'h2);
    read_chk(2'd2, "R3 illegal pair");
    do_write(2'd2, 64'h1);
    read_chk(2'd2, "R3 R7 reg only");
    do_write(2'd2, 64'h0);
    read_chk(2'd2, "R7 sup off");
    do_write(2'd2, 64'h3);
    read_chk(2'd2, "R3 full");

    // R4 and R8: security off masks, on restores.
    do_write(2'd0, 64'h0);
    read_all("R4 security off");
    do_write(2'd0, 64'h1);
    read_all("R8 restore after security");

    // R5: machine register enable off.
    do_write(2'd1, 64'h0);
    read_all("R5 mach reg off");
    do_write(2'd1, 64'h3);
    read_chk(2'd2, "R8 restore after R5");

    // R6: machine mode off.
    do_write(2'd1, 64'h1);
    read_all("R6 mach mode off");
    do_write(2'd1, 64'h3);
    read_chk(2'd2, "R8 restore after R6");

    // R9: narrow supervisor width.
    set_narrow(1'b1, 1'b0);
    read_all("R9 narrow sup");
    set_narrow(1'b0, 1'b0);
    read_all("R9 R8 narrow sup released");

    // R10: narrow user width.
    set_narrow(1'b0, 1'b1);
    read_all("R10 narrow user");
    set_narrow(1'b1, 1'b1);
    read_all("R9 R10 both narrow");
    set_narrow(1'b0, 1'b0);
    read_all("R10 released");

    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule